// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 16-bit data buses, A and B, through non-inverting paths, one for each direction. Each direction owns a capture register with its own rising-edge clock. A select input chooses whether that direction's output carries the live value of the opposite bus or the value held in its register. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Each bidirectional pin is split into an input vector, an output vector and an output enable for its bus, so the block needs no tristate nets. The surrounding logic resolves each bus: the block's drive when its enable is set, and otherwise the external driver or the bus keeper. When both directions drive in live mode, each bus follows the other. The pair then keeps the last value an external driver placed on it, with no register involved.

Top module: `bidir_xcvr_reg`

## Requirements
- R1: When `rst_n` is low, both capture registers are cleared to zero asynchronously. With a select at 1 (storage), that direction's output reads 0.
- R2: The A-to-B register loads `a_in` on each rising edge of `clk_ab`, whatever the values of the selects and enables.
- R3: The B-to-A register loads `b_in` on each rising edge of `clk_ba`, whatever the values of the selects and enables.
- R4: With `sel_ab` = 0, `b_out` equals `a_in` combinationally (live). With `sel_ab` = 1, `b_out` equals the A-to-B register.
- R5: With `sel_ba` = 0, `a_out` equals `b_in` combinationally (live). With `sel_ba` = 1, `a_out` equals the B-to-A register.
- R6: `b_oe` equals `oe_ab`, so bus B is driven only when `oe_ab` is 1.
- R7: `a_oe` is the inverse of `oe_ba_n`, so bus A is driven only when `oe_ba_n` is 0.
- R8: In storage mode an output ignores changes on the opposite bus and edges of the other direction's clock. It changes only after a rising edge of its own direction's clock.
- R9: Every bit passes without inversion and independently of the other bits, in both directions.
- R10: With both enables active and both selects at 0, the resolved buses hold the value an external driver last placed on either bus, after that driver releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both capture registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| sel_ab | input | 1 | Source of bus B drive: 0 live A, 1 stored |
| sel_ba | input | 1 | Source of bus A drive: 0 live B, 1 stored |
| oe_ab | input | 1 | Bus B drive enable, active high |
| oe_ba_n | input | 1 | Bus A drive enable, active low |
| a_in | input | 16 | Resolved value seen on bus A |
| a_out | output | 16 | Value the block drives toward bus A |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | 16 | Resolved value seen on bus B |
| b_out | output | 16 | Value the block drives toward bus B |
| b_oe | output | 1 | Bus B drive enable |

## Verification
A wrong register value appears on the port only while that direction is in storage mode. Once the select is 1 it is visible at once, and it persists until the next edge of that direction's clock. A capture missed or taken from the wrong clock shows at the first storage-mode read after the edge in question. A swapped enable polarity or an inverted bit shows immediately on the enable or data outputs. A fault in the live path shows in the live two-way loop as a pair that drifts or swaps values once the external driver lets go.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned XCVR_WIDTH = 16;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } xfer_src_e;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } cap_state_t;

    cap_state_t state_d;
    cap_state_t state_q;

    // The register loads on every edge; selects and enables never gate it.
    always_comb begin
        state_d      = state_q;
        state_d.data = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.data;
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int unsigned W             = 16,
    parameter bit          EN_ACTIVE_LOW = 1'b0
) (
    input  logic         sel,
    input  logic         en_raw,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] drive,
    output logic         drive_en
);
    xfer_src_e src;

    assign src = xfer_src_e'(sel);

    always_comb begin
        unique case (src)
            SRC_STORED: drive = stored;
            default:    drive = live;
        endcase
    end

    generate
        if (EN_ACTIVE_LOW) begin : g_en_low
            assign drive_en = ~en_raw;
        end else begin : g_en_high
            assign drive_en = en_raw;
        end
    endgenerate
endmodule

// File: rtl/bidir_xcvr_reg.sv
module bidir_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    // A toward B
    xcvr_capture #(.W(W)) u_cap_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (ab_q)
    );

    xcvr_route #(.W(W), .EN_ACTIVE_LOW(1'b0)) u_route_ab (
        .sel      (sel_ab),
        .en_raw   (oe_ab),
        .live     (a_in),
        .stored   (ab_q),
        .drive    (b_out),
        .drive_en (b_oe)
    );

    // B toward A
    xcvr_capture #(.W(W)) u_cap_ba (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (ba_q)
    );

    xcvr_route #(.W(W), .EN_ACTIVE_LOW(1'b1)) u_route_ba (
        .sel      (sel_ba),
        .en_raw   (oe_ba_n),
        .live     (b_in),
        .stored   (ba_q),
        .drive    (a_out),
        .drive_en (a_oe)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int unsigned W = 16
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);
    // Set once a capture edge has occurred outside reset.
    logic ab_seen;
    logic ba_seen;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) ab_seen <= 1'b0;
        else        ab_seen <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) ba_seen <= 1'b0;
        else        ba_seen <= 1'b1;
    end

    // R2: the value shown in storage mode is the bus A value from the last edge
    assert_ab_capture_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (ab_seen && sel_ab) |-> (b_out == $past(a_in)));

    // R3: the same for the B-to-A register
    assert_ba_capture_R3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (ba_seen && sel_ba) |-> (a_out == $past(b_in)));

    // R4: live mode follows bus A
    assert_ab_live_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ab |-> (b_out == a_in));

    // R5: live mode follows bus B
    assert_ba_live_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !sel_ba |-> (a_out == b_in));

    // R6: bus B enable is active high
    assert_b_enable_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        b_oe == oe_ab);

    // R7: bus A enable is active low
    assert_a_enable_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
        a_oe == !oe_ba_n);
endmodule

bind bidir_xcvr_reg xcvr_checker #(.W(W)) u_xcvr_checker (
    .rst_n   (rst_n),
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .oe_ab   (oe_ab),
    .oe_ba_n (oe_ba_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/tb_bidir_xcvr_reg.sv
module tb_bidir_xcvr_reg;
    localparam int unsigned W = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic         rst_n = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0;
    logic         sel_ab = 1'b0, sel_ba = 1'b0;
    logic         oe_ab = 1'b0, oe_ba_n = 1'b1;
    logic [W-1:0] a_bus = '0, b_bus = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    // External drivers on each bus (take priority over the block).
    logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
    logic [W-1:0] a_ext = '0, b_ext = '0;

    // Bench model of the two capture registers.
    logic [W-1:0] exp_ab = '0, exp_ba = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    bidir_xcvr_reg #(.W(W)) dut (
        .rst_n   (rst_n),
        .clk_ab  (clk_ab),
        .clk_ba  (clk_ba),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .a_in    (a_bus),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (b_bus),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bus resolution with keeper: external driver, else block drive, else hold.
    task automatic settle();
        for (int i = 0; i < 3; i++) begin
            #1;
            a_bus = a_ext_en ? a_ext : (a_oe ? a_out : a_bus);
            #1;
            b_bus = b_ext_en ? b_ext : (b_oe ? b_out : b_bus);
        end
        #1;
    endtask

    function automatic logic [W-1:0] exp_b_out();
        return sel_ab ? exp_ab : a_bus;
    endfunction

    function automatic logic [W-1:0] exp_a_out();
        return sel_ba ? exp_ba : b_bus;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R4 b_out"}, b_out, exp_b_out());
        check({tag, " R5 a_out"}, a_out, exp_a_out());
        check({tag, " R6 b_oe"}, {15'd0, b_oe}, {15'd0, oe_ab});
        check({tag, " R7 a_oe"}, {15'd0, a_oe}, {15'd0, !oe_ba_n});
    endtask

    task automatic pulse_ab();
        if (rst_n) exp_ab = a_bus;
        clk_ab = 1'b1;
        #2;
        clk_ab = 1'b0;
        settle();
    endtask

    task automatic pulse_ba();
        if (rst_n) exp_ba = b_bus;
        clk_ba = 1'b1;
        #2;
        clk_ba = 1'b0;
        settle();
    endtask

    initial begin
        void'($urandom(32'h1a2b3c4d));
        a_ext_en = 1'b1; b_ext_en = 1'b1;
        a_ext = 16'hBEEF; b_ext = 16'hCAFE;
        sel_ab = 1'b1; sel_ba = 1'b1;
        settle();
        // R1: reset state in storage mode reads zero
        check("R1 reset b_out", b_out, 16'h0000);
        check("R1 reset a_out", a_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R6 / R7: enable polarity, all four combinations
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            oe_ab = k[0]; oe_ba_n = k[1];
            settle();
            check("R6 b_oe polarity", {15'd0, b_oe}, {15'd0, k[0]});
            check("R7 a_oe polarity", {15'd0, a_oe}, {15'd0, !k[1]});
        end

        // R2 / R3: capture with selects live and enables off, then read stored
        @(negedge clk);
        oe_ab = 1'b0; oe_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
        a_ext = 16'h1357; b_ext = 16'h2468;
        settle();
        pulse_ab();
        pulse_ba();
        @(negedge clk);
        a_ext = 16'h0F0F; b_ext = 16'hF0F0;
        sel_ab = 1'b1; sel_ba = 1'b1;
        settle();
        check("R2 capture regardless of select/enable", b_out, 16'h1357);
        check("R3 capture regardless of select/enable", a_out, 16'h2468);

        // R8: storage output ignores the opposite bus and the other clock
        @(negedge clk);
        a_ext = 16'hAAAA; b_ext = 16'h5555;
        settle();
        check("R8 b_out ignores bus A change", b_out, 16'h1357);
        check("R8 a_out ignores bus B change", a_out, 16'h2468);
        pulse_ba();
        check("R8 b_out ignores clk_ba", b_out, 16'h1357);
        pulse_ab();
        check("R8 b_out updates on clk_ab", b_out, 16'hAAAA);
        check("R8 a_out updated on clk_ba", a_out, 16'h5555);

        // R9: walking ones, live mode, both directions
        @(negedge clk);
        sel_ab = 1'b0; sel_ba = 1'b0;
        for (int i = 0; i < W; i++) begin
            a_ext = 16'h0001 << i;
            b_ext = ~(16'h0001 << i);
            settle();
            check("R9 bit path A to B", b_out, 16'h0001 << i);
            check("R9 bit path B to A", a_out, ~(16'h0001 << i));
        end

        // R10: two-way live loop holds the last external value
        @(negedge clk);
        a_ext = 16'h5A3C; a_ext_en = 1'b1; b_ext_en = 1'b0;
        oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        settle();
        a_ext_en = 1'b0;
        settle();
        check("R10 loop holds on A", a_bus, 16'h5A3C);
        check("R10 loop holds on B", b_bus, 16'h5A3C);
        @(negedge clk);
        b_ext = 16'h9E21; b_ext_en = 1'b1;
        settle();
        b_ext_en = 1'b0;
        settle();
        check("R10 loop holds B value on A", a_bus, 16'h9E21);
        check("R10 loop holds B value on B", b_bus, 16'h9E21);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            sel_ab  = $urandom_range(0, 1);
            sel_ba  = $urandom_range(0, 1);
            oe_ab   = $urandom_range(0, 1);
            oe_ba_n = $urandom_range(0, 1);
            a_ext   = W'($urandom);
            b_ext   = W'($urandom);
            a_ext_en = !(!oe_ba_n);
            b_ext_en = !oe_ab;
            if (oe_ab && !oe_ba_n && !sel_ab && !sel_ba) a_ext_en = 1'b1;
            settle();
            check_all("random");
            if ($urandom_range(0, 2) == 0) begin
                pulse_ab();
                check_all("random after clk_ab R2");
            end
            if ($urandom_range(0, 2) == 0) begin
                pulse_ba();
                check_all("random after clk_ba R3");
            end
        end

        // R1: reset after captures clears both registers
        @(negedge clk);
        oe_ab = 1'b0; oe_ba_n = 1'b1; a_ext_en = 1'b1; b_ext_en = 1'b1;
        sel_ab = 1'b1; sel_ba = 1'b1;
        a_ext = 16'hFFFF; b_ext = 16'hFFFF;
        settle();
        pulse_ab();
        pulse_ba();
        rst_n = 1'b0;
        exp_ab = '0; exp_ba = '0;
        settle();
        check("R1 mid-run reset b_out", b_out, 16'h0000);
        check("R1 mid-run reset a_out", a_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule